// File: doc/BRIEF.md
# Receive Byte Tally with Automatic Last-Byte NACK

This block sits beside the byte engine of an I2C master and handles the receive side of a read message. Every byte the engine finishes is counted and written into a small receive queue. Before each acknowledge slot the block tells the engine whether the next byte gets an ACK or a NACK. A byte limit between 1 and 255 makes the block NACK the byte that reaches the limit on its own, and it then raises a limit-hit pulse. A limit of zero turns the counting off. In that case a manual NACK control input picks the response. A queue-full pulse marks the push that fills the queue.

Software loads the limit, empties the queue, and signals START or repeated START, which clears the running tally. It drains bytes with a pop strobe and can read the tally at any time. When the last byte of a message also fills the queue, the full pulse always comes one cycle before the limit-hit pulse. Issuing STOP after the limit is reached is left to the surrounding control logic.

Top module: `i2c_rx_tally`

## Requirements
- R1: During and after reset the queue is empty, the tally is 0, counting is off, both event outputs are low, and `nack_o` is 0 while `manual_nack_i` is 0.
- R2: Writing a limit (`limit_wr_i`) of 1..255 turns counting on. Writing 0 turns it off. The write also clears the limit-reached state.
- R3: With counting on, `nack_o` is 1 exactly when the tally equals limit−1, so that the next byte is the last one. It stays 1 after the limit is reached. With a limit of 1 it is 1 right after START.
- R4: The byte that brings the tally to the limit gives a one-cycle `cnt_hit_evt_o` pulse. The pulse comes two cycles after the clock edge that took the byte.
- R5: A push that brings the queue level to 8 (no pop in the same cycle) gives a one-cycle `rx_full_evt_o` pulse in the cycle after the edge that took the byte.
- R6: When one byte both fills the queue and reaches the limit, `rx_full_evt_o` comes exactly one cycle before `cnt_hit_evt_o`.
- R7: With counting off, `nack_o` follows `manual_nack_i` and `cnt_hit_evt_o` never pulses.
- R8: `cnt_mon_o` holds the number of bytes taken since the last START, modulo 256. START clears it to 0.
- R9: After the limit is reached, further bytes are ignored until START or a limit write. The tally, the queue level and the events are all unchanged.
- R10: `fifo_flush_i` empties the queue in one cycle and wins over a push or a pop in the same cycle.
- R11: Bytes leave the queue in arrival order at `rd_data_o`. A pop on an empty queue does nothing. A byte that arrives while the queue is full with no pop is dropped but still counted.
- R12: A byte strobe in the same cycle as START is ignored. The tally is cleared to 0 and the queue level is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | START or repeated START seen; clears the tally |
| limit_wr_i | input | 1 | Load strobe for the byte limit |
| limit_i | input | 8 | Byte limit; 0 turns counting off |
| manual_nack_i | input | 1 | NACK request used while counting is off |
| byte_vld_i | input | 1 | One-cycle strobe: a received byte is complete |
| byte_i | input | 8 | Received byte value |
| fifo_flush_i | input | 1 | Empty the receive queue |
| pop_i | input | 1 | Remove the head byte of the queue |
| nack_o | output | 1 | 1 = NACK the next byte, 0 = ACK it |
| rd_data_o | output | 8 | Head byte of the queue |
| fifo_level_o | output | 4 | Number of bytes in the queue |
| rx_full_evt_o | output | 1 | Pulse: the queue has just filled |
| cnt_hit_evt_o | output | 1 | Pulse: the byte limit has been reached |
| cnt_mon_o | output | 8 | Bytes taken since the last START |

## Verification
The bench runs an 8-byte read with a limit of 8. There the last byte both fills the queue and reaches the limit, so a design that raised both pulses in the same cycle, or in the wrong order, shows up at once. It checks a limit of 1, where a design that only armed the NACK after the first byte would ACK a byte it should refuse. It sends a byte after the limit is reached, which catches a tally that keeps counting or a queue that keeps filling. It sends a byte in the same cycle as START, and a flush in the same cycle as a push, to find designs with the wrong priority. In manual mode it sends 256 bytes to test the tally wrap and the dropping of bytes at the full queue, then drains the queue to check the byte order.

// File: rtl/i2c_rx_tally_pkg.sv
package i2c_rx_tally_pkg;

  localparam int unsigned TALLY_W    = 8;
  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned QUEUE_SLOTS = 8;

  // Next-byte response encoding driven on nack_o
  typedef enum logic {
    RESP_ACK  = 1'b0,
    RESP_NACK = 1'b1
  } resp_e;

  // True when the tally sits one below a non-zero limit
  function automatic logic at_final_slot(input logic [TALLY_W-1:0] tally,
                                         input logic [TALLY_W-1:0] limit);
    return (limit != '0) && (tally == limit - 1'b1);
  endfunction

endpackage

// File: rtl/i2c_rx_tally_count.sv
module i2c_rx_tally_count
  import i2c_rx_tally_pkg::*;
#(
  parameter int unsigned CNT_W = TALLY_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             byte_vld_i,
  input  logic             limit_wr_i,
  input  logic [CNT_W-1:0] limit_i,
  input  logic             manual_nack_i,
  output logic             accept_o,
  output logic             hit_o,
  output logic             nack_o,
  output logic [CNT_W-1:0] tally_o
);

  logic [CNT_W-1:0] lim_q, lim_d;
  logic [CNT_W-1:0] tally_q, tally_d;
  logic             done_q, done_d;
  logic             lim_en, tally_en, done_en;
  logic             counting;
  logic             final_slot;
  resp_e            resp;

  assign counting   = (lim_q != '0);
  assign final_slot = counting && (tally_q == lim_q - 1'b1);

  assign accept_o = byte_vld_i & ~start_i & ~done_q;
  assign hit_o    = accept_o & final_slot;

  always_comb begin
    if (done_q)        resp = RESP_NACK;
    else if (counting) resp = final_slot ? RESP_NACK : RESP_ACK;
    else               resp = manual_nack_i ? RESP_NACK : RESP_ACK;
  end
  assign nack_o  = (resp == RESP_NACK);
  assign tally_o = tally_q;

  // next-state
  always_comb begin
    lim_en   = limit_wr_i;
    lim_d    = limit_i;
    tally_en = start_i | accept_o;
    tally_d  = start_i ? '0 : tally_q + 1'b1;
    done_en  = start_i | limit_wr_i | hit_o;
    done_d   = ~(start_i | limit_wr_i);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lim_q   <= '0;
      tally_q <= '0;
      done_q  <= 1'b0;
    end else begin
      if (lim_en)   lim_q   <= lim_d;
      if (tally_en) tally_q <= tally_d;
      if (done_en)  done_q  <= done_d;
    end
  end

  // R3: the byte that reaches the limit is always refused
  a_r3_last_byte_nacked: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> nack_o);

  // R7: no limit-hit while counting is off
  a_r7_off_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (lim_q == '0) |-> !hit_o);

  // R9: once reached, the tally holds until START or a limit write
  a_r9_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !start_i && !limit_wr_i) |=> $stable(tally_q));

endmodule

// File: rtl/i2c_rx_tally_fifo.sv
module i2c_rx_tally_fifo
  import i2c_rx_tally_pkg::*;
#(
  parameter int unsigned DATA_W = BYTE_W,
  parameter int unsigned DEPTH  = QUEUE_SLOTS,
  localparam int unsigned AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned LW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush_i,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic [LW-1:0]     level_o,
  output logic              fill_now_o
);

  logic [DATA_W-1:0] slot_q [DEPTH];
  logic [AW-1:0]     wr_q, wr_d, rd_q, rd_d;
  logic [LW-1:0]     lvl_q, lvl_d;
  logic              pop_ok, push_ok, ptr_en;
  logic              is_full, is_empty;

  assign is_full  = (lvl_q == LW'(DEPTH));
  assign is_empty = (lvl_q == '0);
  assign pop_ok   = pop_i & ~is_empty & ~flush_i;
  assign push_ok  = push_i & ~flush_i & (~is_full | pop_ok);

  assign fill_now_o = push_ok & ~pop_ok & (lvl_q == LW'(DEPTH - 1));
  assign data_o     = slot_q[rd_q];
  assign level_o    = lvl_q;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // next-state
  always_comb begin
    ptr_en = flush_i | push_ok | pop_ok;
    wr_d   = wr_q;
    rd_d   = rd_q;
    lvl_d  = lvl_q;
    if (flush_i) begin
      wr_d  = '0;
      rd_d  = '0;
      lvl_d = '0;
    end else begin
      if (push_ok) wr_d = bump(wr_q);
      if (pop_ok)  rd_d = bump(rd_q);
      if (push_ok && !pop_ok)      lvl_d = lvl_q + 1'b1;
      else if (pop_ok && !push_ok) lvl_d = lvl_q - 1'b1;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      lvl_q <= '0;
    end else if (ptr_en) begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      lvl_q <= lvl_d;
    end
  end

  // storage, one write enable per slot
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic slot_we;
    assign slot_we = push_ok && (wr_q == AW'(g));
    always_ff @(posedge clk) begin
      if (slot_we) slot_q[g] <= data_i;
    end
  end

  // R11: level never exceeds the queue depth
  a_r11_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_q <= LW'(DEPTH));

  // R10: flush empties the queue on the next cycle
  a_r10_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (lvl_q == '0));

endmodule

// File: rtl/i2c_rx_tally_evt.sv
module i2c_rx_tally_evt (
  input  logic clk,
  input  logic rst_n,
  input  logic fill_now_i,
  input  logic hit_now_i,
  output logic full_evt_o,
  output logic hit_evt_o
);

  logic full_q, full_d;
  logic hit_s1_q, hit_s1_d;
  logic hit_q, hit_d;

  // next-state: hit takes one more stage than full, fixing the order
  always_comb begin
    full_d   = fill_now_i;
    hit_s1_d = hit_now_i;
    hit_d    = hit_s1_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q   <= 1'b0;
      hit_s1_q <= 1'b0;
      hit_q    <= 1'b0;
    end else begin
      full_q   <= full_d;
      hit_s1_q <= hit_s1_d;
      hit_q    <= hit_d;
    end
  end

  assign full_evt_o = full_q;
  assign hit_evt_o  = hit_q;

  // R5: the full event is a single-cycle pulse
  a_r5_full_single: assert property (@(posedge clk) disable iff (!rst_n)
    full_evt_o |=> !full_evt_o);

endmodule

// File: rtl/i2c_rx_tally.sv
module i2c_rx_tally
  import i2c_rx_tally_pkg::*;
#(
  parameter int unsigned CNT_W  = TALLY_W,
  parameter int unsigned DATA_W = BYTE_W,
  parameter int unsigned DEPTH  = QUEUE_SLOTS,
  localparam int unsigned LW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              limit_wr_i,
  input  logic [CNT_W-1:0]  limit_i,
  input  logic              manual_nack_i,
  input  logic              byte_vld_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              fifo_flush_i,
  input  logic              pop_i,
  output logic              nack_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [LW-1:0]     fifo_level_o,
  output logic              rx_full_evt_o,
  output logic              cnt_hit_evt_o,
  output logic [CNT_W-1:0]  cnt_mon_o
);

  logic rst_s1_q, rst_s2_q, rst_int_n;
  logic accept, hit, fill_now;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end
  assign rst_int_n = rst_s2_q;

  i2c_rx_tally_count #(.CNT_W(CNT_W)) u_count (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .start_i      (start_i),
    .byte_vld_i   (byte_vld_i),
    .limit_wr_i   (limit_wr_i),
    .limit_i      (limit_i),
    .manual_nack_i(manual_nack_i),
    .accept_o     (accept),
    .hit_o        (hit),
    .nack_o       (nack_o),
    .tally_o      (cnt_mon_o)
  );

  i2c_rx_tally_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .flush_i   (fifo_flush_i),
    .push_i    (accept),
    .pop_i     (pop_i),
    .data_i    (byte_i),
    .data_o    (rd_data_o),
    .level_o   (fifo_level_o),
    .fill_now_o(fill_now)
  );

  i2c_rx_tally_evt u_evt (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .fill_now_i(fill_now),
    .hit_now_i (hit),
    .full_evt_o(rx_full_evt_o),
    .hit_evt_o (cnt_hit_evt_o)
  );

  // R5: a full pulse coincides with a full queue
  a_r5_full_at_depth: assert property (@(posedge clk) disable iff (!rst_int_n)
    rx_full_evt_o |-> (fifo_level_o == LW'(DEPTH)));

  // R12: a byte alongside START is never taken
  a_r12_start_blocks_byte: assert property (@(posedge clk) disable iff (!rst_int_n)
    start_i |=> (cnt_mon_o == '0));

endmodule

// File: tb/i2c_rx_tally_tb_top.sv
module i2c_rx_tally_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       start_i, limit_wr_i, manual_nack_i, byte_vld_i;
  logic       fifo_flush_i, pop_i;
  logic [7:0] limit_i, byte_i;
  logic       nack_o, rx_full_evt_o, cnt_hit_evt_o;
  logic [7:0] rd_data_o, cnt_mon_o;
  logic [3:0] fifo_level_o;

  int n_chk = 0;
  int n_bad = 0;
  logic f1, h1, f2, h2;

  always #4 clk = ~clk;

  i2c_rx_tally dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .limit_wr_i(limit_wr_i),
    .limit_i(limit_i), .manual_nack_i(manual_nack_i), .byte_vld_i(byte_vld_i),
    .byte_i(byte_i), .fifo_flush_i(fifo_flush_i), .pop_i(pop_i),
    .nack_o(nack_o), .rd_data_o(rd_data_o), .fifo_level_o(fifo_level_o),
    .rx_full_evt_o(rx_full_evt_o), .cnt_hit_evt_o(cnt_hit_evt_o),
    .cnt_mon_o(cnt_mon_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle();
    start_i = 0; limit_wr_i = 0; manual_nack_i = 0; byte_vld_i = 0;
    fifo_flush_i = 0; pop_i = 0; limit_i = 0; byte_i = 0;
  endtask

  task automatic pulse_start();
    start_i = 1; @(negedge clk); start_i = 0;
  endtask

  task automatic load_limit(input int v);
    limit_i = v[7:0]; limit_wr_i = 1; @(negedge clk); limit_wr_i = 0;
  endtask

  task automatic flush();
    fifo_flush_i = 1; @(negedge clk); fifo_flush_i = 0;
  endtask

  // drives one byte; samples events in the two following cycles
  task automatic send(input int v);
    byte_i = v[7:0]; byte_vld_i = 1;
    @(negedge clk); byte_vld_i = 0;
    f1 = rx_full_evt_o; h1 = cnt_hit_evt_o;
    @(negedge clk);
    f2 = rx_full_evt_o; h2 = cnt_hit_evt_o;
  endtask

  task automatic pop_expect(input string req, input int exp);
    chk(req, rd_data_o, exp);
    pop_i = 1; @(negedge clk); pop_i = 0;
  endtask

  task automatic t_reset();
    rst_n = 0; idle();
    repeat (3) @(negedge clk);
    chk("R1 level in reset", fifo_level_o, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R1 level", fifo_level_o, 0);
    chk("R1 tally", cnt_mon_o, 0);
    chk("R1 nack", nack_o, 0);
    chk("R1 full evt", rx_full_evt_o, 0);
    chk("R1 hit evt", cnt_hit_evt_o, 0);
  endtask

  task automatic t_limit_three();
    flush(); load_limit(3); pulse_start();
    chk("R3 nack before byte1", nack_o, 0);
    send(8'h11);
    chk("R8 tally 1", cnt_mon_o, 1);
    chk("R3 nack before byte2", nack_o, 0);
    send(8'h22);
    chk("R3 nack before last", nack_o, 1);
    send(8'h33);
    chk("R4 no hit in first cycle", h1, 0);
    chk("R4 R2 hit pulse", h2, 1);
    chk("R5 no full at 3", f1, 0);
    chk("R3 nack held after limit", nack_o, 1);
    @(negedge clk);
    chk("R4 hit single cycle", cnt_hit_evt_o, 0);
    pop_expect("R11 order 0", 8'h11);
    pop_expect("R11 order 1", 8'h22);
    pop_expect("R11 order 2", 8'h33);
    chk("R11 drained", fifo_level_o, 0);
  endtask

  task automatic t_eight_and_ignore();
    flush(); load_limit(8); pulse_start();
    for (int i = 0; i < 7; i++) begin
      send(i + 8'h40);
      chk("R5 no early full", f1 | f2, 0);
      chk("R4 no early hit", h1 | h2, 0);
    end
    send(8'h47);
    chk("R6 full first", f1, 1);
    chk("R6 hit not with full", h1, 0);
    chk("R6 full gone", f2, 0);
    chk("R6 hit second", h2, 1);
    chk("R5 level 8", fifo_level_o, 8);
    send(8'h99);
    chk("R9 tally frozen", cnt_mon_o, 8);
    chk("R9 level frozen", fifo_level_o, 8);
    chk("R9 no events", f1 | h1 | f2 | h2, 0);
    pulse_start();
    chk("R8 start clears", cnt_mon_o, 0);
    chk("R3 nack after restart", nack_o, 0);
  endtask

  task automatic t_manual();
    load_limit(0); flush(); pulse_start();
    manual_nack_i = 0; #1;
    chk("R7 manual ack", nack_o, 0);
    manual_nack_i = 1; #1;
    chk("R7 manual nack", nack_o, 1);
    send(8'h5A);
    chk("R7 R2 no hit when off", h1 | h2, 0);
    chk("R8 tally off mode", cnt_mon_o, 1);
    manual_nack_i = 0;
  endtask

  task automatic t_wrap_overflow();
    int nfull = 0;
    load_limit(0); flush(); pulse_start();
    for (int i = 0; i < 256; i++) begin
      send(i);
      nfull += f1;
      if (h1 | h2) chk("R7 hit in off mode", 1, 0);
    end
    chk("R8 tally wraps", cnt_mon_o, 0);
    chk("R5 one full pulse", nfull, 1);
    chk("R11 level capped", fifo_level_o, 8);
    for (int i = 0; i < 8; i++) pop_expect("R11 drops after full", i);
    pop_i = 1; @(negedge clk); pop_i = 0;
    chk("R11 pop on empty", fifo_level_o, 0);
  endtask

  task automatic t_flush_collide();
    flush(); load_limit(0); pulse_start();
    send(1); send(2);
    byte_i = 3; byte_vld_i = 1; fifo_flush_i = 1;
    @(negedge clk); byte_vld_i = 0; fifo_flush_i = 0;
    chk("R10 flush beats push", fifo_level_o, 0);
  endtask

  task automatic t_start_collide();
    flush(); load_limit(2); pulse_start();
    send(7);
    byte_i = 8; byte_vld_i = 1; start_i = 1;
    @(negedge clk); byte_vld_i = 0; start_i = 0;
    chk("R12 tally cleared", cnt_mon_o, 0);
    chk("R12 byte not queued", fifo_level_o, 1);
  endtask

  task automatic t_limit_one();
    flush(); load_limit(1); pulse_start();
    chk("R3 limit one nack at start", nack_o, 1);
    send(8'hC3);
    chk("R4 limit one hit", h2, 1);
    chk("R8 limit one tally", cnt_mon_o, 1);
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    idle();
    @(negedge clk);
    t_reset();
    t_limit_three();
    t_eight_and_ignore();
    t_manual();
    t_wrap_overflow();
    t_flush_collide();
    t_start_collide();
    t_limit_one();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule